// File: doc/BRIEF.md
# Load/Store Fault Detector

This block watches a processor's memory access stream and flags three kinds of fault in the same cycle that an access or bus response is presented. The three faults are an access whose address is not a multiple of its size, an access outside a programmed stack window, and a bus error returned by the instruction or data side. When a fault is accepted, the block loads a fault-address register and a syndrome register. It may also pulse an exception request for the pipeline control logic.

The syndrome holds a 5-bit cause code. For alignment faults it also records the transfer direction, the register number involved and whether the access was a full word. A global exception-enable input changes how each fault class is treated. Alignment faults are always recorded but only request an exception when the enable is set. Stack faults request regardless of the enable. Bus errors are dropped entirely while the enable is clear.

Top module: `mem_fault_chk`

## Requirements
- R1: Size encoding on `acc_size` is 00 byte, 01 halfword, 10 word (11 behaves as word). A valid access is misaligned when its address bit 0 is set for a halfword, or either of address bits 1..0 is set for a word. Byte accesses are never misaligned.
- R2: On a misaligned access, `fault_addr` takes the access address. `syndrome` takes cause 1 in bits 4..0, the register number in bits 9..5, the write flag in bit 10, and bit 11 set only for a word access.
- R3: The alignment capture of R2 happens whatever the state of `exc_enable`. `exc_req` is raised for it only when `exc_enable` is 1.
- R4: A valid access with `stk_chk_en` set and an address strictly below `stk_lo` or strictly above `stk_hi` captures the address, sets `syndrome` to cause 7 with all other bits zero, and raises `exc_req` regardless of `exc_enable`. Addresses equal to either limit pass.
- R5: A bus error while `exc_enable` is 0 is ignored. It captures nothing and requests nothing, and a lower-priority fault in the same cycle is still handled.
- R6: A bus error while `exc_enable` is 1 captures `bus_err_addr` and sets `syndrome` to cause 2 if `bus_err_ifetch` is 1, or cause 4 otherwise, with all other bits zero. `exc_req` is raised only if `ibus_exc_cfg` (instruction side) or `dbus_exc_cfg` (data side) is set.
- R7: When several faults are present in one cycle, an accepted bus error wins over a stack fault, and a stack fault wins over misalignment.
- R8: Outputs are registered. A fault presented before a clock edge shows on the outputs after that edge, and `exc_req` is high for exactly that one cycle. `fault_addr` and `syndrome` hold until the next captured fault.
- R9: After reset, `fault_addr`, `syndrome` and `exc_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load/store is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | Transfer size: 00 byte, 01 half, 10 word |
| acc_wr | input | 1 | Access is a store |
| acc_reg | input | 5 | Register number of the data operand |
| stk_chk_en | input | 1 | Access is subject to the stack window check |
| stk_lo | input | AW | Lowest allowed stack address |
| stk_hi | input | AW | Highest allowed stack address |
| bus_err | input | 1 | Bus error response this cycle |
| bus_err_ifetch | input | 1 | Bus error came from the instruction side |
| bus_err_addr | input | AW | Address of the erroring bus transfer |
| exc_enable | input | 1 | Global exception enable |
| ibus_exc_cfg | input | 1 | Instruction-side bus errors may raise exceptions |
| dbus_exc_cfg | input | 1 | Data-side bus errors may raise exceptions |
| fault_addr | output | AW | Captured fault address |
| syndrome | output | 12 | Captured fault syndrome |
| exc_req | output | 1 | One-cycle exception request |

## Verification
A wrong priority choice or a wrong cause code shows in `syndrome` and `fault_addr` in the cycle right after the faulting edge. The bench samples every scenario exactly there. A capture-enable fault, such as a dropped bus error that still loads the registers, only shows as a change in values that should have held. So each ignored-stimulus case is compared against the values left by the previous fault. A request that lingers or repeats appears as `exc_req` still high one cycle later, and the idle-cycle scenario is there to catch it.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int SYN_W   = 12;
  localparam int CAUSE_W = 5;
  localparam int REG_W   = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 5'd0,
    CAUSE_UNALIGN = 5'd1,
    CAUSE_IBUS    = 5'd2,
    CAUSE_DBUS    = 5'd4,
    CAUSE_STACK   = 5'd7
  } cause_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef struct packed {
    logic             hit;    // fault recorded
    logic             raise;  // exception requested
    logic [SYN_W-1:0] syn;
  } fault_t;

  function automatic logic [1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 2'b00;
      SZ_HALF: size_mask = 2'b01;
      default: size_mask = 2'b11;
    endcase
  endfunction

  function automatic logic [SYN_W-1:0] plain_syn(input cause_e c);
    plain_syn = {{(SYN_W-CAUSE_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/mfc_align_det.sv
module mfc_align_det
  import mfc_pkg::*;
(
  input  logic             valid,
  input  logic [1:0]       addr_lo,
  input  logic [1:0]       size,
  input  logic             wr,
  input  logic [REG_W-1:0] rnum,
  input  logic             ee,
  output fault_t           flt
);
  logic [1:0] mask;
  logic       is_word;
  logic       misal;

  always_comb begin
    mask    = size_mask(size);
    is_word = (mask == 2'b11);
    misal   = valid && ((addr_lo & mask) != 2'b00);
    flt.hit   = misal;
    flt.raise = misal && ee;
    flt.syn   = '0;
    if (misal) begin
      flt.syn[CAUSE_W-1:0]             = CAUSE_UNALIGN;
      flt.syn[CAUSE_W+REG_W-1:CAUSE_W] = rnum;
      flt.syn[10]                      = wr;
      flt.syn[11]                      = is_word;
    end
  end
endmodule

// File: rtl/mfc_stack_det.sv
module mfc_stack_det
  import mfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic          chk_en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output fault_t        flt
);
  logic below, above, viol;

  always_comb begin
    below     = (addr < lo);
    above     = (addr > hi);
    viol      = valid && chk_en && (below || above);
    flt.hit   = viol;
    flt.raise = viol;
    flt.syn   = viol ? plain_syn(CAUSE_STACK) : '0;
  end
endmodule

// File: rtl/mfc_bus_det.sv
module mfc_bus_det
  import mfc_pkg::*;
(
  input  logic   err,
  input  logic   ifetch,
  input  logic   ee,
  input  logic   icfg,
  input  logic   dcfg,
  output fault_t flt
);
  logic   taken;
  cause_e cause;

  always_comb begin
    taken     = err && ee;
    cause     = ifetch ? CAUSE_IBUS : CAUSE_DBUS;
    flt.hit   = taken;
    flt.raise = taken && (ifetch ? icfg : dcfg);
    flt.syn   = taken ? plain_syn(cause) : '0;
  end
endmodule

// File: rtl/mfc_prio_sel.sv
module mfc_prio_sel
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int NSRC = 3
) (
  input  fault_t        src   [NSRC],  // index 0 is highest priority
  input  logic [AW-1:0] src_a [NSRC],
  output fault_t        win,
  output logic [AW-1:0] win_a
);
  always_comb begin
    win   = '0;
    win_a = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i].hit) begin
        win   = src[i];
        win_a = src_a[i];
      end
    end
  end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_wr,
  input  logic [4:0]    acc_reg,
  input  logic          stk_chk_en,
  input  logic [AW-1:0] stk_lo,
  input  logic [AW-1:0] stk_hi,
  input  logic          bus_err,
  input  logic          bus_err_ifetch,
  input  logic [AW-1:0] bus_err_addr,
  input  logic          exc_enable,
  input  logic          ibus_exc_cfg,
  input  logic          dbus_exc_cfg,
  output logic [AW-1:0] fault_addr,
  output logic [11:0]   syndrome,
  output logic          exc_req
);
  localparam int NSRC = 3;

  fault_t        srcs   [NSRC];
  logic [AW-1:0] src_a  [NSRC];
  fault_t        win;
  logic [AW-1:0] win_a;

  logic [AW-1:0]    addr_q, addr_d;
  logic [SYN_W-1:0] syn_q, syn_d;
  logic             req_q, req_d;
  logic             cap_en;

  mfc_bus_det u_bus (
    .err(bus_err), .ifetch(bus_err_ifetch), .ee(exc_enable),
    .icfg(ibus_exc_cfg), .dcfg(dbus_exc_cfg), .flt(srcs[0])
  );

  mfc_stack_det #(.AW(AW)) u_stk (
    .valid(acc_valid), .chk_en(stk_chk_en), .addr(acc_addr),
    .lo(stk_lo), .hi(stk_hi), .flt(srcs[1])
  );

  mfc_align_det u_aln (
    .valid(acc_valid), .addr_lo(acc_addr[1:0]), .size(acc_size),
    .wr(acc_wr), .rnum(acc_reg), .ee(exc_enable), .flt(srcs[2])
  );

  always_comb begin
    src_a[0] = bus_err_addr;
    src_a[1] = acc_addr;
    src_a[2] = acc_addr;
  end

  mfc_prio_sel #(.AW(AW), .NSRC(NSRC)) u_sel (
    .src(srcs), .src_a(src_a), .win(win), .win_a(win_a)
  );

  // next state
  always_comb begin
    cap_en = win.hit;
    addr_d = cap_en ? win_a   : addr_q;
    syn_d  = cap_en ? win.syn : syn_q;
    req_d  = win.hit && win.raise;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      syn_q  <= syn_d;
      req_q  <= req_d;
    end
  end

  assign fault_addr = addr_q;
  assign syndrome   = syn_q;
  assign exc_req    = req_q;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size,
  input logic          stk_chk_en,
  input logic [AW-1:0] stk_lo,
  input logic [AW-1:0] stk_hi,
  input logic          bus_err,
  input logic          exc_enable,
  input logic [AW-1:0] fault_addr,
  input logic [11:0]   syndrome,
  input logic          exc_req
);
  logic stk_out;
  assign stk_out = acc_valid && stk_chk_en && (acc_addr < stk_lo || acc_addr > stk_hi);

  AST_STACK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_out && !(bus_err && exc_enable)) |=>
      (exc_req && syndrome == 12'd7 && fault_addr == $past(acc_addr))); // R4

  AST_BUS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !exc_enable && !acc_valid) |=>
      (!exc_req && $stable(fault_addr) && $stable(syndrome))); // R5

  AST_WORD_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == 2'b10 && acc_addr[1:0] != 2'b00 && !stk_chk_en
     && !exc_enable) |=>
      (!exc_req && syndrome[11] && syndrome[4:0] == 5'd1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !bus_err) |=>
      (!exc_req && $stable(fault_addr) && $stable(syndrome))); // R8

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (syndrome[4:0] != 5'd0)); // R8
endmodule

bind mem_fault_chk mfc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_size(acc_size), .stk_chk_en(stk_chk_en), .stk_lo(stk_lo),
  .stk_hi(stk_hi), .bus_err(bus_err), .exc_enable(exc_enable),
  .fault_addr(fault_addr), .syndrome(syndrome), .exc_req(exc_req)
);

// File: tb/mem_fault_chk_bench.sv
`timescale 1ns/1ps
module mem_fault_chk_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid, acc_wr, stk_chk_en, bus_err, bus_err_ifetch;
  logic          exc_enable, ibus_exc_cfg, dbus_exc_cfg;
  logic [AW-1:0] acc_addr, stk_lo, stk_hi, bus_err_addr;
  logic [1:0]    acc_size;
  logic [4:0]    acc_reg;
  logic [AW-1:0] fault_addr;
  logic [11:0]   syndrome;
  logic          exc_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mem_fault_chk #(.AW(AW)) u_mem_fault_chk (.*);

  function automatic logic [11:0] al_syn(input logic word, input logic wr,
                                         input logic [4:0] r);
    return {word, wr, r, 5'd1};
  endfunction

  task automatic chk(input string tag, input logic req_e,
                     input logic [AW-1:0] a_e, input logic [11:0] s_e);
    n_cmp++;
    if (exc_req !== req_e || fault_addr !== a_e || syndrome !== s_e) begin
      n_bad++;
      $display("FAIL %s: got req=%0b addr=%h syn=%h, expected req=%0b addr=%h syn=%h",
               tag, exc_req, fault_addr, syndrome, req_e, a_e, s_e);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; acc_addr = '0; acc_size = 2'b00; acc_wr = 0; acc_reg = '0;
    stk_chk_en = 0; bus_err = 0; bus_err_ifetch = 0; bus_err_addr = '0;
  endtask

  // present an access for one edge, then sample just after that edge
  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic wr, input logic [4:0] r, input logic sc);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_size = sz; acc_wr = wr; acc_reg = r;
    stk_chk_en = sc;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R9 reset state", 0, '0, '0);
  endtask

  task automatic t_align();
    exc_enable = 1;
    access(32'h0000_1001, 2'b01, 0, 5'd3, 0);
    chk("R1 R2 half odd", 1, 32'h0000_1001, al_syn(0, 0, 5'd3));
    access(32'h0000_2002, 2'b10, 1, 5'd17, 0);
    chk("R2 word store bit11", 1, 32'h0000_2002, al_syn(1, 1, 5'd17));
    access(32'h0000_3003, 2'b00, 1, 5'd9, 0);
    chk("R1 byte never faults", 0, 32'h0000_2002, al_syn(1, 1, 5'd17));
    access(32'h0000_3004, 2'b10, 0, 5'd9, 0);
    chk("R1 aligned word", 0, 32'h0000_2002, al_syn(1, 1, 5'd17));
    access(32'h0000_3002, 2'b01, 0, 5'd9, 0);
    chk("R1 aligned half", 0, 32'h0000_2002, al_syn(1, 1, 5'd17));
    exc_enable = 0;
    access(32'h0000_4001, 2'b10, 0, 5'd31, 0);
    chk("R3 capture without request", 0, 32'h0000_4001, al_syn(1, 0, 5'd31));
    idle_inputs();
  endtask

  task automatic t_stack();
    stk_lo = 32'h0000_8000; stk_hi = 32'h0000_8FFC;
    exc_enable = 0;
    access(32'h0000_7FFC, 2'b10, 0, 5'd1, 1);
    chk("R4 below low, EE clear", 1, 32'h0000_7FFC, 12'd7);
    exc_enable = 1;
    access(32'h0000_9000, 2'b10, 1, 5'd1, 1);
    chk("R4 above high", 1, 32'h0000_9000, 12'd7);
    access(32'h0000_8000, 2'b10, 1, 5'd1, 1);
    chk("R4 equal low passes", 0, 32'h0000_9000, 12'd7);
    access(32'h0000_8FFC, 2'b10, 1, 5'd1, 1);
    chk("R4 equal high passes", 0, 32'h0000_9000, 12'd7);
    access(32'h0000_0100, 2'b10, 1, 5'd1, 0);
    chk("R4 check disabled", 0, 32'h0000_9000, 12'd7);
    idle_inputs();
  endtask

  task automatic t_bus();
    ibus_exc_cfg = 1; dbus_exc_cfg = 0;
    exc_enable = 0;
    @(negedge clk); bus_err = 1; bus_err_ifetch = 1; bus_err_addr = 32'hAAAA_0000;
    @(posedge clk); #1;
    chk("R5 bus error ignored", 0, 32'h0000_9000, 12'd7);
    idle_inputs();
    exc_enable = 1;
    @(negedge clk); bus_err = 1; bus_err_ifetch = 1; bus_err_addr = 32'hBBBB_0010;
    @(posedge clk); #1;
    chk("R6 ifetch enabled", 1, 32'hBBBB_0010, 12'd2);
    @(negedge clk); bus_err_ifetch = 0; bus_err_addr = 32'hCCCC_0020;
    @(posedge clk); #1;
    chk("R6 data disabled", 0, 32'hCCCC_0020, 12'd4);
    dbus_exc_cfg = 1;
    @(negedge clk); bus_err_addr = 32'hDDDD_0030;
    @(posedge clk); #1;
    chk("R6 data enabled", 1, 32'hDDDD_0030, 12'd4);
    idle_inputs();
  endtask

  task automatic t_priority();
    stk_lo = 32'h0000_8000; stk_hi = 32'h0000_8FFC;
    exc_enable = 1; dbus_exc_cfg = 1;
    @(negedge clk);
    bus_err = 1; bus_err_ifetch = 0; bus_err_addr = 32'h1234_5670;
    @(posedge clk); #0;
    idle_inputs();
    @(negedge clk);
    bus_err = 1; bus_err_ifetch = 0; bus_err_addr = 32'hEEEE_0040;
    acc_valid = 1; acc_addr = 32'h0000_0001; acc_size = 2'b10; stk_chk_en = 1;
    @(posedge clk); #1;
    chk("R7 bus beats stack and align", 1, 32'hEEEE_0040, 12'd4);
    idle_inputs();
    access(32'h0000_0003, 2'b01, 1, 5'd4, 1);
    chk("R7 stack beats align", 1, 32'h0000_0003, 12'd7);
    exc_enable = 0;
    @(negedge clk);
    bus_err = 1; bus_err_addr = 32'hFFFF_0000;
    acc_valid = 1; acc_addr = 32'h0000_8001; acc_size = 2'b01; acc_wr = 0;
    acc_reg = 5'd6; stk_chk_en = 1;
    @(posedge clk); #1;
    chk("R5 R7 dropped bus lets align through", 0, 32'h0000_8001, al_syn(0, 0, 5'd6));
    idle_inputs();
  endtask

  task automatic t_hold();
    exc_enable = 1;
    access(32'h0000_5002, 2'b10, 0, 5'd12, 0);
    chk("R8 request cycle", 1, 32'h0000_5002, al_syn(1, 0, 5'd12));
    idle_inputs();
    @(posedge clk); #1;
    chk("R8 pulse ends, values held", 0, 32'h0000_5002, al_syn(1, 0, 5'd12));
    @(posedge clk); #1;
    chk("R8 still held", 0, 32'h0000_5002, al_syn(1, 0, 5'd12));
  endtask

  bit done = 0;

  initial begin
    idle_inputs();
    exc_enable = 0; ibus_exc_cfg = 0; dbus_exc_cfg = 0;
    stk_lo = '0; stk_hi = '1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_align();
    t_stack();
    t_bus();
    t_priority();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule